// File: doc/BRIEF.md
# Host Message Port with Byte Handshake

This block is the device-side end of a byte-wide parallel host bus. An external controller uses it to pass control messages to an internal processor, one byte at a time, and to collect the bytes that processor sends back. Two address bits choose between a message data register and a read-only status register. The status register reports two handshake flags. The inbound-busy flag shows that the host's last byte has not yet been taken by the core. The outbound-ready flag shows that a byte from the core is waiting to be read. An active-low interrupt line stays asserted while an outbound byte is pending.

The host bus style is fixed by a parameter. In the split-strobe style, an active-low read strobe and an active-low write strobe are qualified by chip select. In the strobe-and-direction style, one active-low data strobe is qualified by chip select, and a direction level selects the transfer (high means read, low means write). Host pins are brought into the core clock through a two-flop synchronizer. A register update takes effect when an access ends, that is, when the active strobe or chip select goes high again. The core side is a plain valid/ready byte interface in each direction.

Top module: `host_msg_port`

## Requirements
- R1: After a synchronous reset, both flags are clear, `hirq_n` is 1, `in_valid` is 0, `out_ready` is 1 and `hdata_oe` is 0.
- R2: A read at `haddr`=0 returns the message byte. A read at `haddr`=1 returns the status byte, with inbound-busy at bit 0, outbound-ready at bit 1 and all other bits zero. Reads at `haddr`=2 or 3 return zero.
- R3: A host write to `haddr`=0 while inbound-busy is clear sets inbound-busy when the access ends. It then presents the written byte on `in_data` with `in_valid` high.
- R4: A host write to `haddr`=0 while inbound-busy is set is ignored, and `in_data` keeps the earlier byte.
- R5: Inbound-busy, which `in_valid` mirrors, clears in the cycle after `in_valid` and `in_ready` are both high.
- R6: `out_ready` is high exactly when outbound-ready is clear. A core transfer (`out_valid` and `out_ready`) loads the byte and sets outbound-ready. While outbound-ready is set, further core offers are not taken.
- R7: A host read of `haddr`=0 while outbound-ready is set returns the core's byte and clears outbound-ready when the access ends.
- R8: `hirq_n` goes low when an outbound byte becomes pending. It stays low through other host accesses until that byte has been read from `haddr`=0.
- R9: `hdata_oe` is high only while chip select is low and a read is in progress. It is low during writes and while the chip is deselected.
- R10: Host writes to `haddr`=1, 2 or 3 change neither flag nor `in_data`.
- R11: Parameter `BUS_STYLE`=0 selects the split-strobe style, with `hstb_n` as the read strobe and `hdir` as the write strobe. `BUS_STYLE`=1 selects the strobe-and-direction style, with `hstb_n` as the data strobe and `hdir` high for read. Both styles give the same register behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hcs_n | input | 1 | Host chip select, active low |
| hstb_n | input | 1 | Read strobe (style 0) or data strobe (style 1), active low |
| hdir | input | 1 | Write strobe, active low (style 0), or direction, 1 = read (style 1) |
| haddr | input | 2 | Host register address |
| hdata_in | input | 8 | Host write data |
| hdata_out | output | 8 | Host read data, zero when not driven |
| hdata_oe | output | 1 | Read-data drive enable for the pad |
| hirq_n | output | 1 | Interrupt request, active low, outbound byte pending |
| in_valid | output | 1 | Inbound byte available to the core |
| in_ready | input | 1 | Core accepts the inbound byte |
| in_data | output | 8 | Inbound byte |
| out_valid | input | 1 | Core offers an outbound byte |
| out_ready | output | 1 | Port can take an outbound byte |
| out_data | input | 8 | Outbound byte from the core |

## Verification
The bench builds two copies with 8-bit data, a 2-bit address and two synchronizer stages, one for each value of `BUS_STYLE`, and runs the same sequence on both. At this width, a sweep of 16 byte patterns that spread across all bit positions sends traffic both ways. It also tries a write while busy and a second core offer while a byte is pending, and it reads every address. All expected values are derived arithmetically from the loop index, which covers both handshake flags, the interrupt hold, and the address decode in both bus styles.

// File: rtl/hmp_pkg.sv
// Shared constants and types for the host message port.
// Assumes a 2-bit address space with the message register at zero.
package hmp_pkg;
    typedef enum logic {
        STYLE_SPLIT      = 1'b0,
        STYLE_STROBE_DIR = 1'b1
    } bus_style_e;

    localparam logic [1:0] ADDR_MSG  = 2'b00;
    localparam logic [1:0] ADDR_STAT = 2'b01;
    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_RDY_BIT  = 1;
endpackage

// File: rtl/hmp_sync.sv
// Multi-stage synchronizer for a bundle of slowly changing host pins.
// Assumes the bundle is stable while a strobe is active, so bus skew is harmless.
module hmp_sync #(
    parameter int               WIDTH   = 8,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the asynchronous pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Later stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hmp_bus_decode.sv
// Turns chip select, strobe and direction pins into read/write activity levels.
// The bus style is fixed at elaboration; pins are active as described per style.
module hmp_bus_decode
    import hmp_pkg::*;
#(
    parameter bus_style_e BUS_STYLE = STYLE_SPLIT
) (
    input  logic cs_n,
    input  logic stb_n,
    input  logic dir,
    output logic rd_act,
    output logic wr_act
);
    if (BUS_STYLE == STYLE_SPLIT) begin : g_split
        // Separate read and write strobes, each gated by chip select.
        always_comb begin
            rd_act = !cs_n && !stb_n;
            wr_act = !cs_n && !dir;
        end
    end else begin : g_strobe_dir
        // One data strobe; direction level high means read.
        always_comb begin
            rd_act = !cs_n && !stb_n && dir;
            wr_act = !cs_n && !stb_n && !dir;
        end
    end
endmodule

// File: rtl/hmp_regs.sv
// Handshake registers: inbound byte with busy flag, outbound byte with ready flag.
// Assumes wr_done/rd_done are single-cycle pulses at the end of a host access.
module hmp_regs
    import hmp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_done,
    input  logic              rd_done,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_data,
    input  logic              in_ready,
    input  logic              out_valid,
    input  logic [DATA_W-1:0] out_data,
    output logic              in_busy,
    output logic [DATA_W-1:0] in_byte,
    output logic              out_rdy,
    output logic [DATA_W-1:0] out_byte
);
    logic acc_msg;
    assign acc_msg = (acc_addr == ADDR_W'(ADDR_MSG));

    // Inbound path: host write fills, core accept drains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_busy <= 1'b0;
            in_byte <= '0;
        end else if (in_busy && in_ready) begin
            in_busy <= 1'b0;
        end else if (wr_done && acc_msg && !in_busy) begin
            in_busy <= 1'b1;
            in_byte <= acc_data;
        end
    end

    // Outbound path: core offer fills, host message read drains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_rdy  <= 1'b0;
            out_byte <= '0;
        end else if (out_rdy && rd_done && acc_msg) begin
            out_rdy <= 1'b0;
        end else if (!out_rdy && out_valid) begin
            out_rdy  <= 1'b1;
            out_byte <= out_data;
        end
    end

    // R3
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_busy) |-> $past(wr_done && acc_msg));
    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_busy && !in_ready |=> in_busy && $stable(in_byte));
    // R5
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_busy) |-> $past(in_ready));
    // R6
    rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_rdy) |-> $past(out_valid));
    // R7
    rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_rdy) |-> $past(rd_done && acc_msg));
endmodule

// File: rtl/host_msg_port.sv
// Top of the host message port. Synchronizes host pins, detects access ends,
// drives read data directly from the live pins, and exposes core valid/ready.
// Assumes address and write data stay stable while the strobe is active.
module host_msg_port
    import hmp_pkg::*;
#(
    parameter bus_style_e BUS_STYLE   = STYLE_SPLIT,
    parameter int         DATA_W      = 8,
    parameter int         ADDR_W      = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hcs_n,
    input  logic              hstb_n,
    input  logic              hdir,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [DATA_W-1:0] hdata_in,
    output logic [DATA_W-1:0] hdata_out,
    output logic              hdata_oe,
    output logic              hirq_n,
    output logic              in_valid,
    input  logic              in_ready,
    output logic [DATA_W-1:0] in_data,
    input  logic              out_valid,
    output logic              out_ready,
    input  logic [DATA_W-1:0] out_data
);
    localparam int SW = 3 + ADDR_W + DATA_W;

    logic [SW-1:0]     pin_raw, pin_sy;
    logic              sy_cs_n, sy_stb_n, sy_dir;
    logic [ADDR_W-1:0] sy_addr, cap_addr;
    logic [DATA_W-1:0] sy_data, cap_data;
    logic              raw_rd, raw_wr, sy_rd, sy_wr, rd_q, wr_q;
    logic              rd_done, wr_done;
    logic              in_busy, out_rdy;
    logic [DATA_W-1:0] in_byte, out_byte, rdata;

    assign pin_raw = {hcs_n, hstb_n, hdir, haddr, hdata_in};

    hmp_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_sy)
    );

    assign {sy_cs_n, sy_stb_n, sy_dir, sy_addr, sy_data} = pin_sy;

    hmp_bus_decode #(.BUS_STYLE(BUS_STYLE)) u_dec_raw (
        .cs_n(hcs_n), .stb_n(hstb_n), .dir(hdir), .rd_act(raw_rd), .wr_act(raw_wr)
    );

    hmp_bus_decode #(.BUS_STYLE(BUS_STYLE)) u_dec_sy (
        .cs_n(sy_cs_n), .stb_n(sy_stb_n), .dir(sy_dir), .rd_act(sy_rd), .wr_act(sy_wr)
    );

    // Track access activity and capture address/data while an access is live.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q     <= 1'b0;
            wr_q     <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            rd_q <= sy_rd;
            wr_q <= sy_wr;
            if (sy_rd || sy_wr) begin
                cap_addr <= sy_addr;
                cap_data <= sy_data;
            end
        end
    end

    assign rd_done = rd_q && !sy_rd;
    assign wr_done = wr_q && !sy_wr;

    hmp_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_done(wr_done), .rd_done(rd_done),
        .acc_addr(cap_addr), .acc_data(cap_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .in_busy(in_busy), .in_byte(in_byte),
        .out_rdy(out_rdy), .out_byte(out_byte)
    );

    // Read mux on the live address, so read data needs no sync latency.
    always_comb begin
        rdata = '0;
        if (haddr == ADDR_W'(ADDR_MSG)) begin
            rdata = out_byte;
        end else if (haddr == ADDR_W'(ADDR_STAT)) begin
            rdata[STAT_BUSY_BIT] = in_busy;
            rdata[STAT_RDY_BIT]  = out_rdy;
        end
    end

    assign hdata_oe  = raw_rd;
    assign hdata_out = raw_rd ? rdata : '0;
    assign hirq_n    = !out_rdy;
    assign in_valid  = in_busy;
    assign in_data   = in_byte;
    assign out_ready = !out_rdy;

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hirq_n && !(rd_done && cap_addr == ADDR_W'(ADDR_MSG)) |=> !hirq_n);
    // R9
    oe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdata_oe |-> !hcs_n && !raw_wr);
    // R10
    other_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done && cap_addr != ADDR_W'(ADDR_MSG) && !in_ready |=> $stable(in_data) && $stable(in_valid));
endmodule

// File: tb/host_msg_port_tb.sv
`timescale 1ns/1ps
module host_msg_port_tb_top;
    import hmp_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       cs0 = 1, stb0 = 1, dir0 = 1;
    logic       cs1 = 1, stb1 = 1, dir1 = 1;
    logic [1:0] haddr = 0;
    logic [7:0] hdin = 0;
    logic       in_ready = 0, out_valid = 0;
    logic [7:0] out_data = 0;

    logic [7:0] hdo0, hdo1, ind0, ind1;
    logic       oe0, oe1, irq0, irq1, inv0, inv1, ordy0, ordy1;

    host_msg_port #(.BUS_STYLE(STYLE_SPLIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .hcs_n(cs0), .hstb_n(stb0), .hdir(dir0),
        .haddr(haddr), .hdata_in(hdin), .hdata_out(hdo0), .hdata_oe(oe0),
        .hirq_n(irq0), .in_valid(inv0), .in_ready(in_ready), .in_data(ind0),
        .out_valid(out_valid), .out_ready(ordy0), .out_data(out_data)
    );

    host_msg_port #(.BUS_STYLE(STYLE_STROBE_DIR)) dut_m (
        .clk(clk), .rst_n(rst_n), .hcs_n(cs1), .hstb_n(stb1), .hdir(dir1),
        .haddr(haddr), .hdata_in(hdin), .hdata_out(hdo1), .hdata_oe(oe1),
        .hirq_n(irq1), .in_valid(inv1), .in_ready(in_ready), .in_data(ind1),
        .out_valid(out_valid), .out_ready(ordy1), .out_data(out_data)
    );

    int  sel = 0;
    int  errors = 0, checks = 0;
    bit  done = 0;

    logic [7:0] c_hdo, c_ind;
    logic       c_oe, c_irq, c_inv, c_ordy;
    always_comb begin
        c_hdo  = sel ? hdo1  : hdo0;
        c_ind  = sel ? ind1  : ind0;
        c_oe   = sel ? oe1   : oe0;
        c_irq  = sel ? irq1  : irq0;
        c_inv  = sel ? inv1  : inv0;
        c_ordy = sel ? ordy1 : ordy0;
    end

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s style=%0d got=%02h exp=%02h", req, sel, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic release_pins();
        cs0 = 1; stb0 = 1; dir0 = 1;
        cs1 = 1; stb1 = 1; dir1 = 1;
    endtask

    // One host access; returns read data and the drive enable seen mid-access.
    task automatic host_op(input bit wr, input logic [1:0] a, input logic [7:0] d,
                           output logic [7:0] rd, output logic oe);
        @(negedge clk);
        haddr = a; hdin = d;
        if (sel == 0) begin
            cs0 = 0;
            if (wr) dir0 = 0; else stb0 = 0;
        end else begin
            cs1 = 0; stb1 = 0; dir1 = wr ? 1'b0 : 1'b1;
        end
        wait_n(4);
        rd = c_hdo; oe = c_oe;
        release_pins();
        wait_n(6);
    endtask

    task automatic core_offer(input logic [7:0] d);
        @(negedge clk);
        out_valid = 1; out_data = d;
        @(negedge clk);
        out_valid = 0;
        wait_n(2);
    endtask

    task automatic core_take();
        @(negedge clk);
        in_ready = 1;
        @(negedge clk);
        in_ready = 0;
        wait_n(2);
    endtask

    task automatic run_phase(input int s);
        logic [7:0] rd;
        logic       oe;
        sel = s;
        release_pins();
        rst_n = 0;
        wait_n(5);
        rst_n = 1;
        wait_n(2);
        // R1 reset state
        check("R1 irq_n", {7'd0, c_irq}, 8'd1);
        check("R1 in_valid", {7'd0, c_inv}, 8'd0);
        check("R1 out_ready", {7'd0, c_ordy}, 8'd1);
        check("R1 oe", {7'd0, c_oe}, 8'd0);
        host_op(0, 2'd1, 8'h00, rd, oe);
        check("R2 status after reset", rd, 8'h00);
        check("R9 oe during read", {7'd0, oe}, 8'd1);
        // R9: strobe active with chip deselected gives no drive
        @(negedge clk);
        if (s == 0) stb0 = 0; else begin stb1 = 0; dir1 = 1; end
        wait_n(2);
        check("R9 oe deselected", {7'd0, c_oe}, 8'd0);
        release_pins();
        wait_n(4);
        for (int k = 0; k < 16; k++) begin
            logic [7:0] v, w;
            v = 8'(k * 17) ^ 8'(s * 8'h3C);
            w = ~v;
            host_op(1, 2'd0, v, rd, oe);
            check("R9 oe during write", {7'd0, oe}, 8'd0);
            check("R3 in_valid", {7'd0, c_inv}, 8'd1);
            check("R3 in_data", c_ind, v);
            host_op(0, 2'd1, 8'h00, rd, oe);
            check("R2 status busy", rd, 8'h01);
            host_op(1, 2'd0, v ^ 8'hA5, rd, oe);
            check("R4 in_data kept", c_ind, v);
            core_take();
            check("R5 in_valid clear", {7'd0, c_inv}, 8'd0);
            check("R6 out_ready idle", {7'd0, c_ordy}, 8'd1);
            core_offer(w);
            check("R6 out_ready full", {7'd0, c_ordy}, 8'd0);
            check("R8 irq low", {7'd0, c_irq}, 8'd0);
            core_offer(w ^ 8'h0F);
            host_op(0, 2'd1, 8'h00, rd, oe);
            check("R2 status ready", rd, 8'h02);
            check("R8 irq held", {7'd0, c_irq}, 8'd0);
            host_op(0, 2'd0, 8'h00, rd, oe);
            check("R7 read byte", rd, w);
            check("R7 irq released", {7'd0, c_irq}, 8'd1);
            host_op(0, 2'd1, 8'h00, rd, oe);
            check("R7 status drained", rd, 8'h00);
        end
        // R10 writes elsewhere are ignored
        for (int a = 1; a < 4; a++) begin
            host_op(1, 2'(a), 8'hFF, rd, oe);
            check("R10 in_valid", {7'd0, c_inv}, 8'd0);
            host_op(0, 2'd1, 8'h00, rd, oe);
            check("R10 status", rd, 8'h00);
        end
        host_op(0, 2'd2, 8'h00, rd, oe);
        check("R2 addr2 zero", rd, 8'h00);
        host_op(0, 2'd3, 8'h00, rd, oe);
        check("R2 addr3 zero", rd, 8'h00);
    endtask

    initial begin
        run_phase(0);   // R11 split strobes
        run_phase(1);   // R11 strobe plus direction
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule